// File: doc/BRIEF.md
# Double-Buffered Multichannel Attenuation Register Bank

This block holds the digital attenuation codes for six DAC channels, arranged as three stereo pairs, and drives them continuously to the audio path. A simple single-cycle write port carries a 7-bit address and a 9-bit word. The low eight bits are the attenuation code, where one step is 0.5 dB and 0xFF means no attenuation. Bit 8 is a commit flag.

Every channel has two levels of storage. A write lands first in the channel's staging register. A write that carries the commit flag then copies all six staged codes to the active outputs on one clock edge, so a full volume change across every channel takes effect at once. A broadcast address loads the same code into all six staging registers. A registered read port returns the staged codes. A one-cycle pulse tells downstream gain logic when new active codes take effect.

Top module: `atten_bank`

## Requirements
- R1: After a synchronous reset, all six staged codes, all six active codes and the broadcast readback value are 0xFF, and `apply_pulse` is 0.
- R2: A write to a channel address with bit 8 = 0 changes only that channel's staged code. `act_codes` keeps its value.
- R3: An accepted write with bit 8 = 1 first stores its code. On that same clock edge it copies all six staged codes, including the new one, to `act_codes`. The new values are visible after that edge.
- R4: Channel addresses are 0x14, 0x15, 0x16, 0x17, 0x18 and 0x19 for left 1, right 1, left 2, right 2, left 3 and right 3. Channel k (k = 0 to 5 in that order) drives `act_codes[8k+7:8k]`.
- R5: A write to the broadcast address 0x1C overwrites all six staged codes with its code. Reading 0x1C returns the last code written there.
- R6: A broadcast write with bit 8 = 1 sets all six active codes to its code in one edge.
- R7: A write to any other address changes no staged code, no active code and the broadcast value, and raises no pulse, even with bit 8 = 1.
- R8: `rd_data` is registered. One cycle after `rd_addr` is presented, it shows the staged code (or the broadcast value) with bit 8 = 0. An unlisted address reads as 0.
- R9: `apply_pulse` is high for exactly the one cycle in which new active codes first appear, and only after a committing write.
- R10: The commit flag is not stored. A later write without the flag does not change `act_codes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 7 | Write address |
| wr_data | input | 9 | [7:0] attenuation code, [8] commit flag |
| rd_addr | input | 7 | Read address |
| rd_data | output | 9 | Registered staged code, bit 8 always 0 |
| act_codes | output | 48 | Six active codes, channel k at [8k+7:8k] |
| apply_pulse | output | 1 | One-cycle strobe when active codes refresh |

## Verification
The hardest situation to reach is a mix of staged values from different sources waiting behind unchanged outputs. In that state, a broadcast has overwritten earlier per-channel staging, and one channel has been staged again on top of it. The vector table builds this up in order: per-channel writes without the flag, a commit, a flag-carrying write to an unlisted address, then a plain broadcast followed by a committing single-channel write. The final committed pattern can only be right if both latch levels and the broadcast merge all behave. Each step also reads back the address just written, so that staged contents are seen while the outputs are still held.

// File: rtl/atten_pkg.sv
package atten_pkg;
  // Default geometry of the attenuation bank
  localparam int unsigned DEF_CODE_W = 8;
  localparam int unsigned DEF_NUM_CH = 6;
  localparam int unsigned DEF_ADDR_W = 7;
  localparam logic [6:0]  DEF_CH_BASE = 7'h14;
  localparam logic [6:0]  DEF_BCAST   = 7'h1C;
  localparam logic [7:0]  DEF_RST_CODE = 8'hFF;

  // Outcome of decoding one address
  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_CHAN  = 2'd1,
    HIT_BCAST = 2'd2
  } hit_kind_e;
endpackage

// File: rtl/atten_addr_dec.sv
module atten_addr_dec
  import atten_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter logic [ADDR_W-1:0] CH_BASE = DEF_CH_BASE,
  parameter logic [ADDR_W-1:0] BCAST   = DEF_BCAST
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ch_hit,
  output logic              bc_hit,
  output hit_kind_e         kind
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_A = CH_BASE + ADDR_W'(i);
    assign ch_hit[i] = (addr == CH_A);
  end

  assign bc_hit = (addr == BCAST);

  always_comb begin
    if (bc_hit)        kind = HIT_BCAST;
    else if (|ch_hit)  kind = HIT_CHAN;
    else               kind = HIT_NONE;
  end
endmodule

// File: rtl/atten_stage.sv
module atten_stage
  import atten_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter logic [CODE_W-1:0] RST_CODE = DEF_RST_CODE,
  localparam int unsigned VEC_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] ch_hit,
  input  logic              bc_hit,
  input  logic [CODE_W-1:0] code,
  output logic [VEC_W-1:0]  stage_q,
  output logic [VEC_W-1:0]  stage_nxt,
  output logic [CODE_W-1:0] bcast_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
    logic [CODE_W-1:0] q;
    logic              load;
    assign load = wr_en && (ch_hit[i] || bc_hit);
    // Next value seen by the commit path on the same edge
    assign stage_nxt[i*CODE_W +: CODE_W] = load ? code : q;
    assign stage_q[i*CODE_W +: CODE_W]   = q;
    always_ff @(posedge clk) begin
      if (rst)       q <= RST_CODE;
      else if (load) q <= code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  bcast_q <= RST_CODE;
    else if (wr_en && bc_hit) bcast_q <= code;
  end
endmodule

// File: rtl/atten_active.sv
module atten_active
  import atten_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter logic [CODE_W-1:0] RST_CODE = DEF_RST_CODE,
  localparam int unsigned VEC_W = NUM_CH * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [VEC_W-1:0] stage_nxt,
  output logic [VEC_W-1:0] act_q,
  output logic             pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= {NUM_CH{RST_CODE}};
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= commit;
      if (commit) act_q <= stage_nxt;
    end
  end

  // R10: without a commit, the active bank never moves
  p_hold_nocommit_r10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_q));
endmodule

// File: rtl/atten_readback.sv
module atten_readback
  import atten_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  localparam int unsigned VEC_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_hit,
  input  logic              bc_hit,
  input  logic [VEC_W-1:0]  stage_q,
  input  logic [CODE_W-1:0] bcast_q,
  output logic [CODE_W:0]   rd_q
);
  logic [CODE_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) sel = stage_q[i*CODE_W +: CODE_W];
    end
    if (bc_hit) sel = bcast_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= {1'b0, sel};
  end
endmodule

// File: rtl/atten_bank.sv
module atten_bank
  import atten_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] CH_BASE = DEF_CH_BASE,
  parameter logic [ADDR_W-1:0] BCAST   = DEF_BCAST,
  parameter logic [CODE_W-1:0] RST_CODE = DEF_RST_CODE,
  localparam int unsigned DATA_W = CODE_W + 1,
  localparam int unsigned VEC_W  = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [VEC_W-1:0]  act_codes,
  output logic              apply_pulse
);
  logic [NUM_CH-1:0] w_ch_hit, r_ch_hit;
  logic              w_bc_hit, r_bc_hit;
  hit_kind_e         w_kind, r_kind;
  logic [VEC_W-1:0]  stage_q, stage_nxt;
  logic [CODE_W-1:0] bcast_q;
  logic              commit;

  atten_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .BCAST(BCAST)) u_wdec (
    .addr(wr_addr), .ch_hit(w_ch_hit), .bc_hit(w_bc_hit), .kind(w_kind));

  atten_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .BCAST(BCAST)) u_rdec (
    .addr(rd_addr), .ch_hit(r_ch_hit), .bc_hit(r_bc_hit), .kind(r_kind));

  assign commit = wr_en && (w_kind != HIT_NONE) && wr_data[CODE_W];

  atten_stage #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .RST_CODE(RST_CODE)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ch_hit(w_ch_hit), .bc_hit(w_bc_hit),
    .code(wr_data[CODE_W-1:0]), .stage_q(stage_q), .stage_nxt(stage_nxt), .bcast_q(bcast_q));

  atten_active #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .RST_CODE(RST_CODE)) u_active (
    .clk(clk), .rst(rst), .commit(commit), .stage_nxt(stage_nxt),
    .act_q(act_codes), .pulse_q(apply_pulse));

  atten_readback #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_rb (
    .clk(clk), .rst(rst), .ch_hit(r_ch_hit), .bc_hit(r_bc_hit),
    .stage_q(stage_q), .bcast_q(bcast_q), .rd_q(rd_data));

  // R1: reset leaves outputs at the default code with no pulse
  p_reset_default_r1: assert property (@(posedge clk)
    rst |=> (act_codes == {NUM_CH{RST_CODE}}) && !apply_pulse);

  // R7: unlisted addresses leave the active bank alone and raise no pulse
  p_ignore_unlisted_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_kind == HIT_NONE) |=> $stable(act_codes) && !apply_pulse);

  // R6: committed broadcast puts one code on every channel
  p_bcast_apply_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == BCAST && wr_data[CODE_W])
      |=> act_codes == {NUM_CH{$past(wr_data[CODE_W-1:0])}});

  // R9: a pulse is always caused by a flagged write in the cycle before
  p_pulse_source_r9: assert property (@(posedge clk) disable iff (rst)
    apply_pulse |-> $past(wr_en && wr_data[CODE_W]));

  // R8: unlisted read addresses return zero
  p_rd_blank_r8: assert property (@(posedge clk) disable iff (rst)
    (r_kind == HIT_NONE) |=> rd_data == '0);
endmodule

// File: tb/atten_bank_tb.sv
`timescale 1ns/1ps
module atten_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [8:0]  rd_data;
  logic [47:0] act_codes;
  logic        apply_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  atten_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .act_codes(act_codes), .apply_pulse(apply_pulse));

  // {addr, data, expected readback, expected act_codes, expected pulse}
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {7'h14, 9'h010, 9'h010, 48'hFFFFFFFFFFFF, 1'b0}, // R2 stage left1
    {7'h17, 9'h020, 9'h020, 48'hFFFFFFFFFFFF, 1'b0}, // R2 stage right2
    {7'h19, 9'h130, 9'h030, 48'h30FF20FFFF10, 1'b1}, // R3 R4 commit
    {7'h15, 9'h040, 9'h040, 48'h30FF20FFFF10, 1'b0}, // R2 R10
    {7'h1A, 9'h155, 9'h000, 48'h30FF20FFFF10, 1'b0}, // R7 unlisted with flag
    {7'h1C, 9'h080, 9'h080, 48'h30FF20FFFF10, 1'b0}, // R5 broadcast stage
    {7'h16, 9'h150, 9'h050, 48'h808080508080, 1'b1}, // R3 R5 merge
    {7'h1C, 9'h1C8, 9'h0C8, 48'hC8C8C8C8C8C8, 1'b1}, // R6 broadcast commit
    {7'h00, 9'h101, 9'h000, 48'hC8C8C8C8C8C8, 1'b0}, // R7 R8
    {7'h13, 9'h000, 9'h000, 48'hC8C8C8C8C8C8, 1'b0}  // R7 R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [8:0] exp, input string req);
    @(negedge clk) rd_addr = a;
    @(negedge clk) chk(req, 64'(rd_data), 64'(exp));
  endtask

  task automatic wr(input logic [6:0] a, input logic [8:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired (R1..all) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 act_codes after reset", 64'(act_codes), 64'hFFFFFFFFFFFF);
    chk("R1 apply_pulse after reset", 64'(apply_pulse), 64'h0);
    for (int a = 'h14; a <= 'h19; a++) rd_chk(7'(a), 9'h0FF, "R1 R8 staged default");
    rd_chk(7'h1C, 9'h0FF, "R1 R5 broadcast default");

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [73:0] e;
      e = VEC[v];
      wr(e[73:67], e[66:58]);
      chk($sformatf("R3 R4 vec%0d act_codes", v), 64'(act_codes), 64'(e[48:1]));
      chk($sformatf("R9 vec%0d pulse", v), 64'(apply_pulse), 64'(e[0]));
      @(negedge clk);
      chk($sformatf("R8 vec%0d readback", v), 64'(rd_data), 64'(e[57:49]));
      chk($sformatf("R9 vec%0d pulse drops", v), 64'(apply_pulse), 64'h0);
    end

    // R10: flag not kept; plain write after commit leaves outputs
    wr(7'h18, 9'h011);
    chk("R10 act after plain write", 64'(act_codes), 64'hC8C8C8C8C8C8);
    chk("R10 no pulse", 64'(apply_pulse), 64'h0);
    rd_chk(7'h18, 9'h011, "R2 staged left3");
    rd_chk(7'h1C, 9'h0C8, "R5 broadcast readback");
    // R7: unlisted write did not touch staging
    rd_chk(7'h14, 9'h0C8, "R7 left1 staging intact");

    // R3: commit picks up earlier staged left3 plus new right1
    wr(7'h15, 9'h1A0);
    chk("R3 commit merges staged", 64'(act_codes), 64'hC811C8C8A0C8);
    chk("R9 pulse on commit", 64'(apply_pulse), 64'h1);

    // R1 mid-run reset
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 act after mid reset", 64'(act_codes), 64'hFFFFFFFFFFFF);
    rd_chk(7'h15, 9'h0FF, "R1 staged after mid reset");
    rd_chk(7'h1C, 9'h0FF, "R1 broadcast after mid reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule